// File: doc/BRIEF.md
# Sticky Status and Alert Controller

This block gathers per-source out-of-limit and fault conditions into one status register whose bits are sticky. A raw condition vector from the limit comparators sets its status bits. A separate, already latched sensor-failure input sets one dedicated status bit. Two active-low outputs with open-drain behaviour are produced from the status register and a vector of per-source interrupt enables. The alert output covers every enabled source. The over-fault output covers only the sensor-failure source.

An ordinary status bit is released only by a read of the status register that arrives while its condition is inactive. A read while the condition is still present leaves the bit set. The sensor-failure bit does not respond to reads at all. It is cleared only by a synchronous reset or a software reset. Masking a source through its enable bit releases the alert without touching the status. Re-enabling that source while its bit is still set pulls the alert low again in the same cycle.

The outputs are pull-low enables. A 1 means the pad is driven low, and a 0 means it is released to its external pull-up. Nothing in the block ever drives a pad high.

Top module: `alert_status_ctrl`

## Requirements
- R1: A status bit other than bit FAIL_BIT (default 5) reads 1 in `status_o` from the clock edge that samples its `cond_i` bit high.
- R2: A read of the status register leaves a bit set if that bit's condition is high in the same cycle as the read. This also holds for a bit that was clear before and whose condition rises in the read cycle, because setting takes priority over clearing.
- R3: A bit other than FAIL_BIT is cleared at the edge where `rd_strobe_i` is 1, `rd_addr_i` equals STAT_ADDR (default 0x02) and its condition is 0. A read at any other address changes nothing, and a set bit never clears without such a read or a reset.
- R4: `cond_i[FAIL_BIT]` has no effect on `status_o`.
- R5: `alert_pull_o` is 1 exactly while at least one status bit is set whose `irq_en_i` bit is 1. Once it has been 1, it falls only after a status read, a software reset or an enable change.
- R6: Clearing an enable bit leaves the status bit unchanged. Setting it back to 1 while the status bit is set makes `alert_pull_o` 1 in the same cycle, with no clock edge needed.
- R7: `status_o[FAIL_BIT]` becomes 1 at the edge that samples `sensor_fail_i` high. It stays 1 through status reads and after `sensor_fail_i` falls.
- R8: `sw_reset` clears every status bit, including FAIL_BIT, at the next edge. It takes priority over any set condition in that cycle.
- R9: `ovr_pull_o` is 1 exactly while `status_o[FAIL_BIT]` and `irq_en_i[FAIL_BIT]` are both 1.
- R10: While `rst` is sampled high, all status bits go to 0, so both pull-low outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_reset | input | 1 | One-cycle software reset strobe |
| cond_i | input | NUM_SRC | Raw out-of-limit conditions, already synchronized |
| sensor_fail_i | input | 1 | Latched remote-sensor failure (short or open) |
| irq_en_i | input | NUM_SRC | Per-source interrupt enables |
| rd_strobe_i | input | 1 | Register read strobe, one cycle |
| rd_addr_i | input | ADDR_W | Address of the register being read |
| status_o | output | NUM_SRC | Status register contents |
| alert_pull_o | output | 1 | 1 pulls the alert pad low |
| ovr_pull_o | output | 1 | 1 pulls the over-fault pad low |

## Verification
The bench reads the status register while a condition is still present and checks that the bit survives. A design that cleared on every read would lose the event. It also raises a condition in the very cycle of a clearing read, where a clear-wins priority would drop the bit. It reads at a neighbouring address, masks and re-enables a source with its bit still set, and drives the raw condition line that sits at the sensor-failure position. These steps catch an address decode that is too loose, a mask that wipes status, a re-enable that waits for a new event, and a failure bit that can be set through the wrong input. Finally, it reads and releases the sensor failure to prove that the bit persists, then uses the software reset to prove that this reset alone releases the bit.

// File: rtl/alert_status_ctrl.sv
module alert_status_ctrl #(
  parameter int              NUM_SRC   = 8,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h02,
  parameter int              FAIL_BIT  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_reset,
  input  logic [NUM_SRC-1:0] cond_i,
  input  logic               sensor_fail_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               rd_strobe_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               alert_pull_o,
  output logic               ovr_pull_o
);

  logic [NUM_SRC-1:0] stat_q;
  logic               rd_hit;

  assign rd_hit = rd_strobe_i && (rd_addr_i == STAT_ADDR);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (i == FAIL_BIT) begin : g_fail
      always_ff @(posedge clk) begin
        if (rst || sw_reset) stat_q[i] <= 1'b0;
        else if (sensor_fail_i) stat_q[i] <= 1'b1;
      end
    end else begin : g_norm
      always_ff @(posedge clk) begin
        if (rst || sw_reset) stat_q[i] <= 1'b0;
        else if (cond_i[i]) stat_q[i] <= 1'b1;
        else if (rd_hit) stat_q[i] <= 1'b0;
      end
    end
  end

  assign status_o     = stat_q;
  assign alert_pull_o = |(stat_q & irq_en_i);
  assign ovr_pull_o   = stat_q[FAIL_BIT] & irq_en_i[FAIL_BIT];

endmodule

// File: rtl/alert_status_ctrl_chk.sv
module alert_status_ctrl_chk #(
  parameter int                NUM_SRC   = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h02,
  parameter int                FAIL_BIT  = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               sw_reset,
  input logic [NUM_SRC-1:0] cond_i,
  input logic               rd_strobe_i,
  input logic [ADDR_W-1:0]  rd_addr_i,
  input logic [NUM_SRC-1:0] irq_en_i,
  input logic [NUM_SRC-1:0] status_o,
  input logic               alert_pull_o,
  input logic               ovr_pull_o
);

  localparam logic [NUM_SRC-1:0] NORM = ~(NUM_SRC'(1) << FAIL_BIT);

  logic hit;
  assign hit = rd_strobe_i && (rd_addr_i == STAT_ADDR);

  // R1
  cond_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|(cond_i & NORM) && !sw_reset) |=>
      ((status_o & $past(cond_i & NORM)) == $past(cond_i & NORM)));

  // R3
  no_spurious_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_reset && !hit) |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o[FAIL_BIT] && !sw_reset) |=> status_o[FAIL_BIT]);

  // R8
  sw_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sw_reset |=> (status_o == '0));

  // R5
  alert_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(alert_pull_o) |->
      ($past(rd_strobe_i) || $past(sw_reset) || (irq_en_i != $past(irq_en_i))));

  // R9
  ovr_needs_fail_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_pull_o |-> (status_o[FAIL_BIT] && irq_en_i[FAIL_BIT]));

endmodule

bind alert_status_ctrl alert_status_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .FAIL_BIT(FAIL_BIT)
) u_chk (
  .clk(clk), .rst(rst), .sw_reset(sw_reset), .cond_i(cond_i),
  .rd_strobe_i(rd_strobe_i), .rd_addr_i(rd_addr_i), .irq_en_i(irq_en_i),
  .status_o(status_o), .alert_pull_o(alert_pull_o), .ovr_pull_o(ovr_pull_o)
);

// File: tb/alert_status_ctrl_test.sv
module alert_status_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic       clk = 1'b0;
  logic       rst, sw_reset, sensor_fail, rd;
  logic [7:0] cond, en, addr, status;
  logic       alert, ovr;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alert_status_ctrl uut (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .cond_i(cond),
    .sensor_fail_i(sensor_fail), .irq_en_i(en), .rd_strobe_i(rd),
    .rd_addr_i(addr), .status_o(status), .alert_pull_o(alert), .ovr_pull_o(ovr)
  );

  // fields: cond[35:28] sf[27] en[26:19] rd[18] addr[17:10] stat[9:2] alert[1] ovr[0]
  localparam logic [35:0] VEC [NV] = '{
    {8'h01, 1'b0, 8'hFF, 1'b0, 8'h00, 8'h01, 1'b1, 1'b0},
    {8'h01, 1'b0, 8'hFF, 1'b1, 8'h02, 8'h01, 1'b1, 1'b0},
    {8'h00, 1'b0, 8'hFF, 1'b0, 8'h00, 8'h01, 1'b1, 1'b0},
    {8'h00, 1'b0, 8'hFF, 1'b1, 8'h03, 8'h01, 1'b1, 1'b0},
    {8'h00, 1'b0, 8'hFF, 1'b1, 8'h02, 8'h00, 1'b0, 1'b0},
    {8'h82, 1'b0, 8'h02, 1'b0, 8'h00, 8'h82, 1'b1, 1'b0},
    {8'h80, 1'b0, 8'h02, 1'b1, 8'h02, 8'h80, 1'b0, 1'b0},
    {8'h80, 1'b0, 8'h00, 1'b0, 8'h00, 8'h80, 1'b0, 1'b0},
    {8'h00, 1'b0, 8'h80, 1'b0, 8'h00, 8'h80, 1'b1, 1'b0},
    {8'h20, 1'b0, 8'hFF, 1'b0, 8'h00, 8'h80, 1'b1, 1'b0},
    {8'h00, 1'b1, 8'hFF, 1'b0, 8'h00, 8'hA0, 1'b1, 1'b1},
    {8'h00, 1'b0, 8'hFF, 1'b1, 8'h02, 8'h20, 1'b1, 1'b1},
    {8'h00, 1'b0, 8'hDF, 1'b0, 8'h00, 8'h20, 1'b0, 1'b0},
    {8'h00, 1'b0, 8'h20, 1'b0, 8'h00, 8'h20, 1'b1, 1'b1}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1 set";
      1: return "R2 read while active";
      2: return "R3 sticky without read";
      3: return "R3 other address";
      4: return "R3 clearing read";
      5: return "R5 enabled source";
      6: return "R5 masked source";
      7: return "R6 mask keeps status";
      8: return "R6 re-enable";
      9: return "R4 raw fail line";
      10: return "R7 R9 sensor fail";
      11: return "R7 read ignored";
      12: return "R9 masked";
      default: return "R9 re-enabled";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [9:0] exp);
    checks++;
    if ({status, alert, ovr} !== exp) begin
      errors++;
      $display("FAIL %s: got stat=%h alert=%b ovr=%b, expected stat=%h alert=%b ovr=%b",
               tag, status, alert, ovr, exp[9:2], exp[1], exp[0]);
    end
  endtask

  task automatic step(input logic [7:0] c, input logic sf, input logic [7:0] e,
                      input logic r, input logic [7:0] a, input logic sr);
    @(negedge clk);
    cond = c; sensor_fail = sf; en = e; rd = r; addr = a; sw_reset = sr;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; sw_reset = 1'b0; cond = 8'hFF; sensor_fail = 1'b1;
    en = 8'hFF; rd = 1'b0; addr = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 held in reset", 10'h000);
    @(negedge clk);
    rst = 1'b0; cond = 8'h00; sensor_fail = 1'b0;
    @(posedge clk);
    #1;
    chk("R10 after reset", 10'h000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][35:28], VEC[i][27], VEC[i][26:19], VEC[i][18], VEC[i][17:10], 1'b0);
      chk(vec_tag(i), VEC[i][9:0]);
    end

    // R8: software reset releases the failure bit
    step(8'h00, 1'b0, 8'hFF, 1'b0, 8'h00, 1'b1);
    chk("R8 sw reset", 10'h000);
    // R8: sw reset wins over set condition
    step(8'h08, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b1);
    chk("R8 sw reset priority", 10'h000);
    // R2: condition rises in the same cycle as a clearing read
    step(8'h04, 1'b0, 8'hFF, 1'b1, 8'h02, 1'b0);
    chk("R2 set wins over read", {8'h04, 1'b1, 1'b0});
    step(8'h00, 1'b0, 8'h00, 1'b1, 8'h02, 1'b0);
    chk("R3 read clears masked bit", 10'h000);
    // R10: synchronous reset clears pending status
    step(8'h11, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0);
    chk("R1 R7 set before reset", {8'h31, 1'b1, 1'b1});
    @(negedge clk);
    rst = 1'b1; cond = 8'h00; sensor_fail = 1'b0;
    @(posedge clk);
    #1;
    chk("R10 reset clears", 10'h000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule